// File: doc/BRIEF.md
# Code Protection Security Register

This block holds the one-time-clearable protection bits of an on-chip program memory and applies them to every path that could carry protected code off the chip. Like a flash cell, each protection bit can be programmed from one to zero but never back. Only a chip-wide erase restores the bits, and that erase also wipes the code they protect. Three bits decide three separate paths. One controls programmer reads of the code array and of the protection registers. One decides whether table reads issued from external program space may reach internal code. One turns on the encoding of programmer read data before it reaches the external port.

The block includes a small modelled code array so the effect of an erase can be seen. It also holds an 8-bit key register used by the encoder, which is a plain XOR of the outgoing byte with the key. Programming-mode writes and programmer reads use one address bus. Table reads use a separate address, a flag that says whether the issuing instruction was fetched from external program space, and the byte that external memory returns.

Top module: `codeguard_top`

## Requirements
- R1: A programming-mode write to address 0xFFFF sets the security byte to its old value AND the write data, so a bit at 0 stays 0 whatever is written.
- R2: A one-cycle `erase_all` pulse sets the security byte, the key register and every code word to 0xFF. It wins over a write in the same cycle.
- R3: Writes apply only while `prog_mode` is 1. Address 0xFFFE is the key register and addresses below `DEPTH` (64) are code words, both with AND-only programming. A write while `prog_mode` is 0 changes nothing.
- R4: While bit 0 (lock) of the security byte is 0, a programmer read of a code word, of 0xFFFF or of 0xFFFE returns 0xFF with `pgm_denied` set.
- R5: While bit 1 (table inhibit) is 0, a table read with `tbl_from_ext`=1 to an internal address (below `DEPTH`) returns 0xFF with `tbl_denied` set. The same read to an external address returns `ext_din`.
- R6: A table read with `tbl_from_ext`=0 is never denied and returns the code word for an internal address, or `ext_din` for an external one.
- R7: While bit 1 is 1, table reads from either origin are never denied, and internal addresses return code.
- R8: While bit 2 (encode) is 0, an allowed programmer read returns the stored byte XOR the key register. While bit 2 is 1, the byte is returned unchanged.
- R9: Each read returns its data one clock after the request, with `*_valid` high for exactly that cycle. A denied result is 0xFF and is not encoded. `*_valid` and `*_denied` are 0 in any cycle that follows no request.
- R10: After reset every stored byte is 0xFF, so the security byte reads back as 0xFF with no denial, and all outputs are 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | 1 selects programming mode |
| addr | input | 16 | Programming-mode address |
| wr_en | input | 1 | Programming write strobe |
| wr_data | input | 8 | Programming write data |
| erase_all | input | 1 | Full-chip erase strobe |
| prg_rd | input | 1 | Programmer read request |
| pgm_dout | output | 8 | Programmer read data, possibly encoded |
| pgm_valid | output | 1 | Programmer read data valid |
| pgm_denied | output | 1 | Programmer read refused |
| tbl_rd | input | 1 | Table read request |
| tbl_from_ext | input | 1 | Table read was issued from external program space |
| tbl_addr | input | 16 | Table read address |
| ext_din | input | 8 | Byte returned by external memory |
| tbl_dout | output | 8 | Table read data |
| tbl_valid | output | 1 | Table read data valid |
| tbl_denied | output | 1 | Table read refused |

## Verification
The embedded properties watch every cycle for the following: a security bit rising without an erase, an erase that leaves any byte or code word un-erased, a write that lands outside programming mode, a locked programmer read or a blocked external table read that is not refused, an internal-origin or uninhibited table read that is refused, and valid or denied flags held past their request. Some behaviour depends on exact data values and only the directed scenarios can show it. These include the AND result of repeated programming, the XOR-encoded bytes, the 0xFF data and the destruction of code after an erase, and the priority of erase over a same-cycle write.

// File: rtl/cg_pkg.sv
package cg_pkg;
   typedef enum logic [1:0] {
      TGT_CODE = 2'd0,
      TGT_SEC  = 2'd1,
      TGT_KEY  = 2'd2,
      TGT_NONE = 2'd3
   } tgt_e;
endpackage

// File: rtl/cg_sec_reg.sv
module cg_sec_reg #(
   parameter int DATA_W   = 8,
   parameter int LOCK_BIT = 0,
   parameter int INH_BIT  = 1,
   parameter int ENC_BIT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_all,
   input  logic              wr_sec,
   input  logic              wr_key,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] sec_q,
   output logic [DATA_W-1:0] key_q,
   output logic              lock_ok,
   output logic              tbl_free,
   output logic              enc_on
);
   localparam logic [DATA_W-1:0] ERASED = '1;

   if (LOCK_BIT >= DATA_W || INH_BIT >= DATA_W || ENC_BIT >= DATA_W) begin : g_bad_pos
      $error("cg_sec_reg: control bit position outside the byte");
   end
   if (LOCK_BIT == INH_BIT || LOCK_BIT == ENC_BIT || INH_BIT == ENC_BIT) begin : g_bad_dup
      $error("cg_sec_reg: control bit positions must differ");
   end

   // cells only ever move from 1 to 0 until erased
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= ERASED;
         key_q <= ERASED;
      end else if (erase_all) begin
         sec_q <= ERASED;
         key_q <= ERASED;
      end else begin
         if (wr_sec) sec_q <= sec_q & wr_data;
         if (wr_key) key_q <= key_q & wr_data;
      end
   end

   assign lock_ok  = sec_q[LOCK_BIT];
   assign tbl_free = sec_q[INH_BIT];
   assign enc_on   = ~sec_q[ENC_BIT];

   p_no_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_all |=> ((sec_q & ~$past(sec_q)) == '0))
      else $error("security bit rose without erase");

   p_key_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_all |=> ((key_q & ~$past(key_q)) == '0))
      else $error("key bit rose without erase");

   p_erase_regs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      erase_all |=> (sec_q == ERASED && key_q == ERASED))
      else $error("erase left protection bytes set");
endmodule

// File: rtl/cg_code_array.sv
module cg_code_array #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_all,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_data_b
);
   localparam logic [DATA_W-1:0] ERASED = '1;

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         mem[i] <= ERASED;
         else if (erase_all) mem[i] <= ERASED;
         else if (hit)       mem[i] <= mem[i] & wr_data;
      end

      p_row_erased_r2: assert property (@(posedge clk) disable iff (!rst_n)
         erase_all |=> (mem[i] == ERASED))
         else $error("code word survived erase");
   end

   assign rd_data_a = mem[rd_idx_a];
   assign rd_data_b = mem[rd_idx_b];
endmodule

// File: rtl/cg_read_gate.sv
module cg_read_gate #(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                prg_rd,
   input  cg_pkg::tgt_e        prg_tgt,
   input  logic [DATA_W-1:0]   code_a,
   input  logic [DATA_W-1:0]   sec_q,
   input  logic [DATA_W-1:0]   key_q,
   input  logic                lock_ok,
   input  logic                enc_on,
   output logic [DATA_W-1:0]   pgm_dout,
   output logic                pgm_valid,
   output logic                pgm_denied,
   input  logic                tbl_rd,
   input  logic                tbl_from_ext,
   input  logic                tbl_internal,
   input  logic                tbl_free,
   input  logic [DATA_W-1:0]   code_b,
   input  logic [DATA_W-1:0]   ext_din,
   output logic [DATA_W-1:0]   tbl_dout,
   output logic                tbl_valid,
   output logic                tbl_denied
);
   import cg_pkg::*;
   localparam logic [DATA_W-1:0] REFUSED = '1;

   logic [DATA_W-1:0] prg_raw;
   logic              prg_block;
   logic              tbl_block;

   always_comb begin
      case (prg_tgt)
         TGT_CODE: prg_raw = code_a;
         TGT_SEC:  prg_raw = sec_q;
         TGT_KEY:  prg_raw = key_q;
         default:  prg_raw = REFUSED;
      endcase
   end

   assign prg_block = !lock_ok && (prg_tgt != TGT_NONE);
   assign tbl_block = tbl_from_ext && !tbl_free && tbl_internal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pgm_dout   <= '0;
         pgm_valid  <= 1'b0;
         pgm_denied <= 1'b0;
      end else begin
         pgm_valid  <= prg_rd;
         pgm_denied <= prg_rd && prg_block;
         if (prg_rd) begin
            if (prg_block)   pgm_dout <= REFUSED;
            else if (enc_on) pgm_dout <= prg_raw ^ key_q;
            else             pgm_dout <= prg_raw;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_dout   <= '0;
         tbl_valid  <= 1'b0;
         tbl_denied <= 1'b0;
      end else begin
         tbl_valid  <= tbl_rd;
         tbl_denied <= tbl_rd && tbl_block;
         if (tbl_rd) begin
            if (tbl_block)         tbl_dout <= REFUSED;
            else if (tbl_internal) tbl_dout <= code_b;
            else                   tbl_dout <= ext_din;
         end
      end
   end

   p_lock_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (prg_rd && !lock_ok && prg_tgt != TGT_NONE) |=> (pgm_denied && pgm_dout == REFUSED))
      else $error("locked programmer read not refused");

   p_ext_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_rd && tbl_from_ext && !tbl_free && tbl_internal) |=> (tbl_denied && tbl_dout == REFUSED))
      else $error("external table read reached internal code");

   p_int_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_rd && !tbl_from_ext) |=> (tbl_valid && !tbl_denied))
      else $error("internal-origin table read refused");

   p_no_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_rd && tbl_free) |=> !tbl_denied)
      else $error("table read refused with inhibit clear");

   p_plain_sec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prg_rd && lock_ok && !enc_on && prg_tgt == TGT_SEC) |=> (pgm_dout == $past(sec_q)))
      else $error("unencoded security read altered");

   p_pgm_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !prg_rd |=> (!pgm_valid && !pgm_denied))
      else $error("programmer flags without request");

   p_tbl_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tbl_rd |=> (!tbl_valid && !tbl_denied))
      else $error("table flags without request");
endmodule

// File: rtl/codeguard_top.sv
module codeguard_top #(
   parameter int          ADDR_W   = 16,
   parameter int          DATA_W   = 8,
   parameter int          DEPTH    = 64,
   parameter logic [15:0] SEC_ADDR = 16'hFFFF,
   parameter logic [15:0] KEY_ADDR = 16'hFFFE,
   parameter int          LOCK_BIT = 0,
   parameter int          INH_BIT  = 1,
   parameter int          ENC_BIT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_mode,
   input  logic [15:0]       addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              erase_all,
   input  logic              prg_rd,
   output logic [7:0]        pgm_dout,
   output logic              pgm_valid,
   output logic              pgm_denied,
   input  logic              tbl_rd,
   input  logic              tbl_from_ext,
   input  logic [15:0]       tbl_addr,
   input  logic [7:0]        ext_din,
   output logic [7:0]        tbl_dout,
   output logic              tbl_valid,
   output logic              tbl_denied
);
   import cg_pkg::*;
   localparam int IDX_W = $clog2(DEPTH);

   if (ADDR_W != 16 || DATA_W != 8) begin : g_bad_width
      $error("codeguard_top: port widths fixed at 16-bit address, 8-bit data");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("codeguard_top: DEPTH must be a power of two");
   end
   if (KEY_ADDR < DEPTH || SEC_ADDR < DEPTH || KEY_ADDR == SEC_ADDR) begin : g_bad_map
      $error("codeguard_top: register addresses overlap the code array");
   end

   tgt_e              tgt;
   logic              wr_ok;
   logic              tbl_internal;
   logic [DATA_W-1:0] sec_q, key_q, code_a, code_b;
   logic              lock_ok, tbl_free, enc_on;

   always_comb begin
      if (addr[ADDR_W-1:IDX_W] == '0) tgt = TGT_CODE;
      else if (addr == SEC_ADDR)      tgt = TGT_SEC;
      else if (addr == KEY_ADDR)      tgt = TGT_KEY;
      else                            tgt = TGT_NONE;
   end

   assign wr_ok        = prog_mode && wr_en;
   assign tbl_internal = (tbl_addr[ADDR_W-1:IDX_W] == '0);

   cg_sec_reg #(
      .DATA_W(DATA_W), .LOCK_BIT(LOCK_BIT), .INH_BIT(INH_BIT), .ENC_BIT(ENC_BIT)
   ) u_sec (
      .clk      (clk),
      .rst_n    (rst_n),
      .erase_all(erase_all),
      .wr_sec   (wr_ok && tgt == TGT_SEC),
      .wr_key   (wr_ok && tgt == TGT_KEY),
      .wr_data  (wr_data),
      .sec_q    (sec_q),
      .key_q    (key_q),
      .lock_ok  (lock_ok),
      .tbl_free (tbl_free),
      .enc_on   (enc_on)
   );

   cg_code_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .erase_all(erase_all),
      .wr_en    (wr_ok && tgt == TGT_CODE),
      .wr_idx   (addr[IDX_W-1:0]),
      .wr_data  (wr_data),
      .rd_idx_a (addr[IDX_W-1:0]),
      .rd_data_a(code_a),
      .rd_idx_b (tbl_addr[IDX_W-1:0]),
      .rd_data_b(code_b)
   );

   cg_read_gate #(.DATA_W(DATA_W)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .prg_rd      (prg_rd && prog_mode),
      .prg_tgt     (tgt),
      .code_a      (code_a),
      .sec_q       (sec_q),
      .key_q       (key_q),
      .lock_ok     (lock_ok),
      .enc_on      (enc_on),
      .pgm_dout    (pgm_dout),
      .pgm_valid   (pgm_valid),
      .pgm_denied  (pgm_denied),
      .tbl_rd      (tbl_rd),
      .tbl_from_ext(tbl_from_ext),
      .tbl_internal(tbl_internal),
      .tbl_free    (tbl_free),
      .code_b      (code_b),
      .ext_din     (ext_din),
      .tbl_dout    (tbl_dout),
      .tbl_valid   (tbl_valid),
      .tbl_denied  (tbl_denied)
   );

   p_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_mode && !erase_all) |=> ($stable(sec_q) && $stable(key_q)))
      else $error("protection bytes changed outside programming mode");
endmodule

// File: tb/tb_codeguard_top.sv
`timescale 1ns/1ps
module tb_codeguard_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_mode = 1'b0;
   logic [15:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        erase_all = 1'b0;
   logic        prg_rd = 1'b0;
   logic [7:0]  pgm_dout;
   logic        pgm_valid, pgm_denied;
   logic        tbl_rd = 1'b0;
   logic        tbl_from_ext = 1'b0;
   logic [15:0] tbl_addr = '0;
   logic [7:0]  ext_din = '0;
   logic [7:0]  tbl_dout;
   logic        tbl_valid, tbl_denied;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   codeguard_top dut (.*);

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pwrite(input logic [15:0] a, input logic [7:0] d, input logic pm);
      @(negedge clk);
      prog_mode = pm; addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; prog_mode = 1'b1;
   endtask

   task automatic pread(input string req, input logic [15:0] a,
                        input logic [7:0] exp_d, input logic exp_den);
      @(negedge clk);
      prog_mode = 1'b1; addr = a; prg_rd = 1'b1;
      @(negedge clk);
      prg_rd = 1'b0;
      check(req, {15'd0, pgm_valid}, 16'd1);
      check(req, {15'd0, pgm_denied}, {15'd0, exp_den});
      check(req, {8'd0, pgm_dout}, {8'd0, exp_d});
   endtask

   task automatic tread(input string req, input logic [15:0] a, input logic from_ext,
                        input logic [7:0] ext, input logic [7:0] exp_d, input logic exp_den);
      @(negedge clk);
      tbl_addr = a; tbl_from_ext = from_ext; ext_din = ext; tbl_rd = 1'b1;
      @(negedge clk);
      tbl_rd = 1'b0;
      check(req, {15'd0, tbl_valid}, 16'd1);
      check(req, {15'd0, tbl_denied}, {15'd0, exp_den});
      check(req, {8'd0, tbl_dout}, {8'd0, exp_d});
   endtask

   task automatic t_reset;
      check("R10 valid", {15'd0, pgm_valid}, 16'd0);
      check("R10 tdout", {8'd0, tbl_dout}, 16'd0);
      pread("R10 sec erased", 16'hFFFF, 8'hFF, 1'b0);
      pread("R10 code erased", 16'h0005, 8'hFF, 1'b0);
   endtask

   task automatic t_program_code;
      pwrite(16'h0005, 8'h3C, 1'b1);
      pread("R3 code write", 16'h0005, 8'h3C, 1'b0);
      pwrite(16'h0005, 8'hF0, 1'b1);
      pread("R3 and-only code", 16'h0005, 8'h30, 1'b0);
      pwrite(16'h0006, 8'h00, 1'b0);
      pread("R3 write outside prog mode", 16'h0006, 8'hFF, 1'b0);
      pwrite(16'hFFFF, 8'h00, 1'b0);
      pread("R3 sec write outside prog mode", 16'hFFFF, 8'hFF, 1'b0);
   endtask

   task automatic t_table_open;
      tread("R7 ext origin internal code", 16'h0005, 1'b1, 8'hA5, 8'h30, 1'b0);
      tread("R7 ext origin external", 16'h1000, 1'b1, 8'hA5, 8'hA5, 1'b0);
   endtask

   task automatic t_sec_and_only;
      pwrite(16'hFFFF, 8'hFD, 1'b1);
      pread("R1 clear inhibit", 16'hFFFF, 8'hFD, 1'b0);
      pwrite(16'hFFFF, 8'hFF, 1'b1);
      pread("R1 no set back", 16'hFFFF, 8'hFD, 1'b0);
   endtask

   task automatic t_table_gated;
      tread("R5 ext origin internal blocked", 16'h0005, 1'b1, 8'hA5, 8'hFF, 1'b0 | 1'b1);
      tread("R5 ext origin external ok", 16'h1000, 1'b1, 8'h5C, 8'h5C, 1'b0);
      tread("R6 int origin internal", 16'h0005, 1'b0, 8'hA5, 8'h30, 1'b0);
      tread("R6 int origin external", 16'h2000, 1'b0, 8'h96, 8'h96, 1'b0);
      @(negedge clk);
      check("R9 tbl valid drops", {15'd0, tbl_valid}, 16'd0);
      check("R9 tbl denied drops", {15'd0, tbl_denied}, 16'd0);
   endtask

   task automatic t_encode;
      pwrite(16'hFFFE, 8'h5A, 1'b1);
      pread("R3 key plain", 16'hFFFE, 8'h5A, 1'b0);
      pwrite(16'hFFFF, 8'hF9, 1'b1);
      pread("R8 code encoded", 16'h0005, 8'h6A, 1'b0);
      pread("R8 sec encoded", 16'hFFFF, 8'hA3, 1'b0);
   endtask

   task automatic t_lock;
      pwrite(16'hFFFF, 8'hFE, 1'b1);
      pread("R4 code refused", 16'h0005, 8'hFF, 1'b1);
      pread("R4 sec refused", 16'hFFFF, 8'hFF, 1'b1);
      pread("R4 key refused", 16'hFFFE, 8'hFF, 1'b1);
      @(negedge clk);
      check("R9 pgm valid drops", {15'd0, pgm_valid}, 16'd0);
      check("R9 pgm denied drops", {15'd0, pgm_denied}, 16'd0);
      tread("R6 table unaffected by lock", 16'h0005, 1'b0, 8'h00, 8'h30, 1'b0);
   endtask

   task automatic t_erase;
      @(negedge clk);
      erase_all = 1'b1;
      @(negedge clk);
      erase_all = 1'b0;
      pread("R2 sec restored", 16'hFFFF, 8'hFF, 1'b0);
      pread("R2 key restored", 16'hFFFE, 8'hFF, 1'b0);
      pread("R2 code destroyed", 16'h0005, 8'hFF, 1'b0);
      tread("R2 table sees erased code", 16'h0005, 1'b1, 8'h11, 8'hFF, 1'b0);
      pwrite(16'hFFFF, 8'h00, 1'b1);
      @(negedge clk);
      prog_mode = 1'b1; addr = 16'hFFFF; wr_data = 8'h00; wr_en = 1'b1; erase_all = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; erase_all = 1'b0;
      pread("R2 erase beats write", 16'hFFFF, 8'hFF, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program_code();
      t_table_open();
      t_sec_and_only();
      t_table_gated();
      t_encode();
      t_lock();
      t_erase();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule